// File: doc/BRIEF.md
# Display Power-Save Sync Controller

This block is the last stage before a CRT DAC and a flat panel. An external timing generator supplies raw horizontal sync, vertical sync and display-enable, all active-high, plus the pixel colour. The block gates each sync with its own enable and drives it at a programmable polarity. It forces the colour outputs to zero when the DAC output is blanked, and it drives the panel power control bit.

Software sets up the block through a small register port. The configuration register sits at offset 0x08 and holds the sync enables, the DAC enable, both polarities and a stored sync-skew field; the skew field is not applied to the outputs. The panel power register sits at offset 0x410.

A separate 3-bit power-save command moves the block between five display states in one cycle. It changes only the enables and the panel power bit. The polarity and skew settings are left as they are.

Top module: `dps_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00010000 (skew field, bits 16:14, equal to 4, every other bit 0), the panel register reads 0, panel_pwr is 0, both sync outputs are 1, crt_rgb is 0 and ps_cmd_err is 0.
- R2: A write to offset 0x08 stores bit 1 (hsync enable), bit 2 (vsync enable), bit 3 (DAC enable), bit 8 (hsync active-high), bit 9 (vsync active-high) and bits 16:14 (skew). All other bits of that register read 0. A write to offset 0x410 stores bit 24 (panel power), which drives panel_pwr, and all other bits of that register read 0.
- R3: A valid command sets {hsync enable, vsync enable, DAC enable} as follows. Code 0 (unblank) gives {1,1,1}. Code 1 (normal blank) gives {1,1,0}. Code 2 (vsync suspend) gives {1,0,0}. Code 3 (hsync suspend) gives {0,1,0}. Code 4 (powerdown) gives {0,0,0}. The new values can be read back one cycle later.
- R4: Command code 4 clears the panel power bit, and codes 0 to 3 set it.
- R5: A command leaves the polarity bits and the skew field unchanged.
- R6: Command codes 5, 6 and 7 change no register. ps_cmd_err is 1 for exactly the one cycle that follows the command.
- R7: An enabled sync output follows its raw input one cycle later. It is at the polarity level (1 if active-high is selected, 0 otherwise) when the raw sync was 1, and at the opposite level when the raw sync was 0.
- R8: A disabled sync output sits at its inactive level, which is 0 for active-high and 1 for active-low, whatever its raw input does.
- R9: crt_rgb equals the pixel input from one cycle earlier when the DAC enable and display-enable were both 1 in that cycle, and equals 0 otherwise.
- R10: When a configuration write and a valid command arrive in the same cycle, the command sets the three enable bits and the panel bit, and the write sets the polarity and skew fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ps_cmd_valid | input | 1 | Power-save command strobe |
| ps_cmd | input | 3 | Power-save command code |
| ps_cmd_err | output | 1 | One-cycle pulse after a rejected command |
| tg_hsync | input | 1 | Raw horizontal sync, active-high |
| tg_vsync | input | 1 | Raw vertical sync, active-high |
| tg_de | input | 1 | Raw display-enable |
| pix_in | input | 24 | Pixel colour from the pipeline |
| crt_hsync | output | 1 | Gated, polarity-adjusted horizontal sync |
| crt_vsync | output | 1 | Gated, polarity-adjusted vertical sync |
| crt_rgb | output | 24 | Colour to the DAC, zero while blanked |
| panel_pwr | output | 1 | Panel power control |

## Verification
A corrupted enable bit shows up at the ports one cycle after it is stored. It appears as a sync that toggles when it should sit idle, a sync stuck at its idle level, or colour leaking through while the DAC is blanked. It also shows in the configuration read-back at once. A wrong polarity bit inverts both the idle level and the asserted level of its sync on the next cycle. A command decode that accepts an illegal code leaves changed enables in the read-back and no error pulse. Panel power mistakes appear on panel_pwr in the cycle after the command.

// File: rtl/dps_pkg.sv
package dps_pkg;

    // Bit positions software relies on
    localparam int HS_EN_BIT  = 1;
    localparam int VS_EN_BIT  = 2;
    localparam int DAC_EN_BIT = 3;
    localparam int HPOL_BIT   = 8;
    localparam int VPOL_BIT   = 9;
    localparam int SKEW_LSB   = 14;
    localparam int SKEW_W     = 3;
    localparam int PANEL_BIT  = 24;
    localparam logic [SKEW_W-1:0] SKEW_RST = 3'd4;

    typedef enum logic [2:0] {
        PS_UNBLANK = 3'd0,
        PS_BLANK   = 3'd1,
        PS_VSUSP   = 3'd2,
        PS_HSUSP   = 3'd3,
        PS_PWRDN   = 3'd4
    } ps_mode_e;

    typedef struct packed {
        logic [SKEW_W-1:0] skew;
        logic              vpol;
        logic              hpol;
        logic              dac_en;
        logic              vs_en;
        logic              hs_en;
    } cfg_t;

    typedef struct packed {
        logic ok;
        logic hs;
        logic vs;
        logic dac;
        logic panel;
    } ps_act_t;

    function automatic ps_act_t ps_decode(input logic [2:0] code);
        ps_act_t a;
        a = '0;
        case (code)
            PS_UNBLANK: a = '{ok: 1'b1, hs: 1'b1, vs: 1'b1, dac: 1'b1, panel: 1'b1};
            PS_BLANK:   a = '{ok: 1'b1, hs: 1'b1, vs: 1'b1, dac: 1'b0, panel: 1'b1};
            PS_VSUSP:   a = '{ok: 1'b1, hs: 1'b1, vs: 1'b0, dac: 1'b0, panel: 1'b1};
            PS_HSUSP:   a = '{ok: 1'b1, hs: 1'b0, vs: 1'b1, dac: 1'b0, panel: 1'b1};
            PS_PWRDN:   a = '{ok: 1'b1, hs: 1'b0, vs: 1'b0, dac: 1'b0, panel: 1'b0};
            default:    a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dps_regs.sv
module dps_regs
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h008,
    parameter logic [ADDR_W-1:0] PNL_OFS = 12'h410
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    output cfg_t              cfg,
    output logic              panel,
    output logic              cmd_err
);

    typedef struct packed {
        cfg_t cfg;
        logic panel;
        logic err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        cfg:   '{skew: SKEW_RST, vpol: 1'b0, hpol: 1'b0,
                 dac_en: 1'b0, vs_en: 1'b0, hs_en: 1'b0},
        panel: 1'b0,
        err:   1'b0
    };

    regs_t   regs_d, regs_q;
    ps_act_t act;
    logic    cfg_hit, pnl_hit;

    wire unused_wdata = ^wdata;

    assign cfg_hit = (addr == CFG_OFS);
    assign pnl_hit = (addr == PNL_OFS);

    always_comb begin
        act    = ps_decode(cmd);
        regs_d = regs_q;
        regs_d.err = 1'b0;
        if (wr_en && cfg_hit) begin
            regs_d.cfg.hs_en  = wdata[HS_EN_BIT];
            regs_d.cfg.vs_en  = wdata[VS_EN_BIT];
            regs_d.cfg.dac_en = wdata[DAC_EN_BIT];
            regs_d.cfg.hpol   = wdata[HPOL_BIT];
            regs_d.cfg.vpol   = wdata[VPOL_BIT];
            regs_d.cfg.skew   = wdata[SKEW_LSB +: SKEW_W];
        end
        if (wr_en && pnl_hit) begin
            regs_d.panel = wdata[PANEL_BIT];
        end
        // Command overrides the enables and panel bit of a same-cycle write
        if (cmd_valid) begin
            if (act.ok) begin
                regs_d.cfg.hs_en  = act.hs;
                regs_d.cfg.vs_en  = act.vs;
                regs_d.cfg.dac_en = act.dac;
                regs_d.panel      = act.panel;
            end else begin
                regs_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (cfg_hit) begin
            rdata[HS_EN_BIT]             = regs_q.cfg.hs_en;
            rdata[VS_EN_BIT]             = regs_q.cfg.vs_en;
            rdata[DAC_EN_BIT]            = regs_q.cfg.dac_en;
            rdata[HPOL_BIT]              = regs_q.cfg.hpol;
            rdata[VPOL_BIT]              = regs_q.cfg.vpol;
            rdata[SKEW_LSB +: SKEW_W]    = regs_q.cfg.skew;
        end else if (pnl_hit) begin
            rdata[PANEL_BIT]             = regs_q.panel;
        end
    end

    assign cfg     = regs_q.cfg;
    assign panel   = regs_q.panel;
    assign cmd_err = regs_q.err;

endmodule

// File: rtl/dps_sync_gate.sv
module dps_sync_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic en,
    input  logic pol,
    output logic sync_out
);

    logic out_d, out_q;

    // Asserted level equals pol, idle level is its inverse
    always_comb begin
        out_d = (en && raw) ? pol : ~pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= out_d;
    end

    assign sync_out = out_q;

endmodule

// File: rtl/dps_video_gate.sv
module dps_video_gate #(
    parameter int RGB_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dac_en,
    input  logic             de,
    input  logic [RGB_W-1:0] pix,
    output logic [RGB_W-1:0] rgb
);

    logic [RGB_W-1:0] rgb_d, rgb_q;

    always_comb begin
        rgb_d = (dac_en && de) ? pix : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    assign rgb = rgb_q;

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int RGB_W  = 24,
    parameter logic [ADDR_W-1:0] CFG_OFS = 12'h008,
    parameter logic [ADDR_W-1:0] PNL_OFS = 12'h410
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ps_cmd_valid,
    input  logic [2:0]        ps_cmd,
    output logic              ps_cmd_err,
    input  logic              tg_hsync,
    input  logic              tg_vsync,
    input  logic              tg_de,
    input  logic [RGB_W-1:0]  pix_in,
    output logic              crt_hsync,
    output logic              crt_vsync,
    output logic [RGB_W-1:0]  crt_rgb,
    output logic              panel_pwr
);

    localparam int N_AXIS = 2;

    cfg_t              cfg_w;
    logic [N_AXIS-1:0] raw_s, en_s, pol_s, out_s;

    dps_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CFG_OFS(CFG_OFS),
        .PNL_OFS(PNL_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cmd_valid(ps_cmd_valid),
        .cmd      (ps_cmd),
        .cfg      (cfg_w),
        .panel    (panel_pwr),
        .cmd_err  (ps_cmd_err)
    );

    // Axis 0 horizontal, axis 1 vertical
    assign raw_s = {tg_vsync, tg_hsync};
    assign en_s  = {cfg_w.vs_en, cfg_w.hs_en};
    assign pol_s = {cfg_w.vpol, cfg_w.hpol};

    for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
        dps_sync_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_s[g]),
            .en      (en_s[g]),
            .pol     (pol_s[g]),
            .sync_out(out_s[g])
        );
    end

    assign crt_hsync = out_s[0];
    assign crt_vsync = out_s[1];

    dps_video_gate #(.RGB_W(RGB_W)) u_video (
        .clk   (clk),
        .rst_n (rst_n),
        .dac_en(cfg_w.dac_en),
        .de    (tg_de),
        .pix   (pix_in),
        .rgb   (crt_rgb)
    );

endmodule

// File: rtl/dps_chk.sv
module dps_chk
    import dps_pkg::*;
#(
    parameter int RGB_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             ps_cmd_valid,
    input logic [2:0]       ps_cmd,
    input logic             ps_cmd_err,
    input logic             tg_de,
    input logic [RGB_W-1:0] crt_rgb,
    input logic             crt_hsync,
    input logic             crt_vsync,
    input logic             panel_pwr,
    input cfg_t             cfg
);

    // R4
    pwrdn_panel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_cmd_valid && ps_cmd == 3'd4) |=> !panel_pwr);

    // R4
    active_panel_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_cmd_valid && ps_cmd < 3'd4) |=> panel_pwr);

    // R6
    bad_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_cmd_valid && ps_cmd > 3'd4 && !reg_wr_en) |=> ($stable(cfg) && $stable(panel_pwr)));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_cmd_err |-> ($past(ps_cmd_valid) && $past(ps_cmd) > 3'd4));

    // R9
    rgb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crt_rgb != '0) |-> ($past(tg_de) && $past(cfg.dac_en)));

    // R8
    hs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg.hs_en) |-> (crt_hsync == !$past(cfg.hpol)));

    // R8
    vs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg.vs_en) |-> (crt_vsync == !$past(cfg.vpol)));

endmodule

bind dps_ctrl dps_chk #(.RGB_W(RGB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .ps_cmd_valid(ps_cmd_valid),
    .ps_cmd      (ps_cmd),
    .ps_cmd_err  (ps_cmd_err),
    .tg_de       (tg_de),
    .crt_rgb     (crt_rgb),
    .crt_hsync   (crt_hsync),
    .crt_vsync   (crt_vsync),
    .panel_pwr   (panel_pwr),
    .cfg         (cfg_w)
);

// File: tb/dps_ctrl_bench.sv
`timescale 1ns/1ps
module dps_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = 12'h008;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ps_cmd_valid = 1'b0;
    logic [2:0]  ps_cmd = '0;
    logic        ps_cmd_err;
    logic        tg_hsync = 1'b0, tg_vsync = 1'b0, tg_de = 1'b0;
    logic [23:0] pix_in = '0;
    logic        crt_hsync, crt_vsync, panel_pwr;
    logic [23:0] crt_rgb;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dps_ctrl u_dps_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ps_cmd_valid(ps_cmd_valid), .ps_cmd(ps_cmd), .ps_cmd_err(ps_cmd_err),
        .tg_hsync(tg_hsync), .tg_vsync(tg_vsync), .tg_de(tg_de), .pix_in(pix_in),
        .crt_hsync(crt_hsync), .crt_vsync(crt_vsync), .crt_rgb(crt_rgb),
        .panel_pwr(panel_pwr)
    );

    // {cmd, hs, vs, dac, panel, err}
    localparam logic [7:0] VEC [10] = '{
        {3'd0, 5'b11110}, {3'd1, 5'b11010}, {3'd2, 5'b10010}, {3'd3, 5'b01010},
        {3'd4, 5'b00000}, {3'd5, 5'b00001}, {3'd0, 5'b11110}, {3'd6, 5'b11111},
        {3'd3, 5'b01010}, {3'd7, 5'b01011}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = 12'h008;
    endtask

    task automatic cmd(input logic [2:0] c);
        @(negedge clk);
        ps_cmd_valid = 1'b1; ps_cmd = c;
        @(negedge clk);
        ps_cmd_valid = 1'b0;
    endtask

    task automatic rd_cfg(output logic [31:0] v);
        reg_addr = 12'h008; #0.1; v = reg_rdata;
    endtask

    task automatic run_all();
        logic [31:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_cfg(v);          chk("R1 cfg reset", v, 32'h0001_0000);
        reg_addr = 12'h410; #0.1;
        chk("R1 panel reg reset", reg_rdata, 32'h0);
        reg_addr = 12'h008;
        chk("R1 outputs reset", {crt_hsync, crt_vsync, panel_pwr, ps_cmd_err},
            {28'h0, 4'b1100});
        chk("R1 rgb reset", {8'h0, crt_rgb}, 32'h0);

        // R2 field storage and masking
        wr(12'h008, 32'hFFFF_FFFF);
        rd_cfg(v);          chk("R2 cfg mask", v, 32'h0001_C30E);
        wr(12'h410, 32'hFFFF_FFFF);
        reg_addr = 12'h410; #0.1;
        chk("R2 panel mask", reg_rdata, 32'h0100_0000);
        chk("R2 panel pin", {31'h0, panel_pwr}, 32'h1);
        wr(12'h410, 32'h0);
        wr(12'h008, 32'h0000_8100);
        rd_cfg(v);          chk("R2 cfg write", v, 32'h0000_8100);

        // R3 R4 R6 command table
        for (int i = 0; i < 10; i++) begin
            logic [7:0] e;
            e = VEC[i];
            cmd(e[7:5]);
            rd_cfg(v);
            chk("R3 R6 cfg after cmd", v,
                32'h0000_8100 | {28'h0, e[2], e[3], e[4], 1'b0});
            chk("R4 panel after cmd", {31'h0, panel_pwr}, {31'h0, e[1]});
            chk("R6 err pulse", {31'h0, ps_cmd_err}, {31'h0, e[0]});
            @(negedge clk);
            chk("R6 err one cycle", {31'h0, ps_cmd_err}, 32'h0);
        end
        // R5 polarity and skew untouched by commands
        rd_cfg(v);          chk("R5 pol skew kept", v & 32'h0001_C300, 32'h0000_8100);

        // R7 enabled syncs, hpol=1 vpol=0
        cmd(3'd0);
        tg_hsync = 1'b1; tg_vsync = 1'b1;
        @(negedge clk);
        chk("R7 asserted levels", {30'h0, crt_hsync, crt_vsync}, 32'b10);
        tg_hsync = 1'b0; tg_vsync = 1'b0;
        @(negedge clk);
        chk("R7 idle levels", {30'h0, crt_hsync, crt_vsync}, 32'b01);

        // R8 disabled syncs ignore raw input
        cmd(3'd4);
        tg_hsync = 1'b1; tg_vsync = 1'b1;
        @(negedge clk);
        chk("R8 disabled hpol1 vpol0", {30'h0, crt_hsync, crt_vsync}, 32'b01);
        wr(12'h008, 32'h0000_0200);
        @(negedge clk);
        chk("R8 disabled hpol0 vpol1", {30'h0, crt_hsync, crt_vsync}, 32'b10);
        tg_hsync = 1'b0; tg_vsync = 1'b0;

        // R9 colour gating
        cmd(3'd0);
        tg_de = 1'b1; pix_in = 24'hA5C33C;
        @(negedge clk);
        chk("R9 pass", {8'h0, crt_rgb}, 32'h00A5_C33C);
        tg_de = 1'b0;
        @(negedge clk);
        chk("R9 de low", {8'h0, crt_rgb}, 32'h0);
        cmd(3'd1);
        tg_de = 1'b1;
        @(negedge clk);
        chk("R9 dac off", {8'h0, crt_rgb}, 32'h0);
        tg_de = 1'b0;

        // R10 same-cycle write and command
        cmd(3'd4);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h008; reg_wdata = 32'h0000_030E;
        ps_cmd_valid = 1'b1; ps_cmd = 3'd2;
        @(negedge clk);
        reg_wr_en = 1'b0; ps_cmd_valid = 1'b0;
        rd_cfg(v);          chk("R10 merge", v, 32'h0000_0302);
        chk("R10 panel", {31'h0, panel_pwr}, 32'h1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule